// File: doc/BRIEF.md
# Control-Register Parallel Write Sequencer

This block is a hardware master for the parallel control-register port of a PHY. The port has a 16-bit address, a 16-bit write-data word, a select line, a write-enable line and a slow port clock that the block produces itself. The PHY answers on a single acknowledge line. A command comes in over a valid/ready handshake and is one of two kinds: a register write, or a port-ready check that is run once after the PHY leaves reset.

For a write, the block first runs a burst of port-clock pulses with select high. It then drops select, presents the data with write-enable, and finally drives the address with select and the port clock both high. After that it watches the acknowledge, which it samples only at the end of each clock-high level, and gives a bounded number of clock attempts before it reports a failure along with the address. For the ready check, the block parks the port, gives one clock pulse, and polls the acknowledge at a fixed tick until it drops or a timeout expires.

The half-period of the port clock is taken from an input, in system clocks, when a command is accepted. Each operation ends with a one-cycle done pulse that carries a pass/fail status and the address.

Top module: `crp_write_master`

## Requirements
- R1: `cmd_ready` is high only while idle. A command is accepted on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_ready` stays low from the next cycle until the done cycle, and commands offered in that time have no effect.
- R2: Each port step (every port-clock level and every setup level) lasts exactly H system clocks. H is the value of `half_period` captured at acceptance, and a value of 0 counts as 1. A later change of `half_period` does not affect an operation already running.
- R3: A write (`cmd_kind`=0) first raises select with the clock low for one step. It then emits exactly 15 port-clock pulses, each one a high step followed by a low step, with select high throughout.
- R4: After the burst, select goes low for one step. Next, write data and write-enable are driven together with select and clock low, one step before the address appears.
- R5: The address is driven in the same cycle that select and the port clock go high, and the port clock is never high while select is low.
- R6: The acknowledge is sampled only in the last system clock of each clock-high step of the address phase. If it is 1 there, the write ends successfully. If it is not, the clock goes low for one step and then high again.
- R7: If 10 such samples all see 0, the write ends with `done_ok`=0 and `done_addr` set to the write address.
- R8: At the end of any operation, the port clock and write-enable are low in the done cycle, and the block is idle again. Select, address and data keep their last values.
- R9: A ready check (`cmd_kind`=1) drives clock low, address 0, data 0, write-enable low and select high for one step. It then gives one port-clock pulse, and the acknowledge is ignored during these three steps.
- R10: After the pulse, the ready check samples the acknowledge every POLL_CYCLES system clocks, with the first sample at the end of the first interval. A 0 ends it with `done_ok`=1. If READY_POLLS samples all see 1, it ends with `done_ok`=0.
- R11: `done` is a one-cycle pulse, given once per operation. `done_ok` and `done_addr` are valid with it, and `done_addr` is 0 for a ready check.
- R12: After reset every port output is 0, `done` is 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period | input | HALF_W | Port-clock half-period in system clocks, captured at acceptance |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to accept |
| cmd_kind | input | 1 | 0 = register write, 1 = ready check |
| cmd_addr | input | ADDR_W | Register address for a write |
| cmd_data | input | DATA_W | Write data |
| port_clk | output | 1 | Slow port clock |
| port_sel | output | 1 | Port select |
| port_wr_en | output | 1 | Port write enable |
| port_addr | output | ADDR_W | Port address |
| port_wdata | output | DATA_W | Port write data |
| port_ack | input | 1 | Acknowledge from the PHY |
| done | output | 1 | One-cycle end-of-operation pulse |
| done_ok | output | 1 | Status with `done`: 1 pass, 0 fail or timeout |
| done_addr | output | ADDR_W | Address of the finished operation |

## Verification
The bound checker watches, on every cycle, the rules that hold at any time. These are: ready dropping after an accept, the clock never high without select, write-enable rising only while select and clock are low, the clean port state in the done cycle, and done lasting a single cycle. Other properties depend on a whole sequence and can only be shown by the bench scenarios. These are the exact count of 15 pre-clock pulses, step lengths that follow the captured half-period (including zero), and the acknowledge being ignored everywhere except the last cycle of a clock-high step. They also cover success on the first and on the tenth attempt, failure after ten attempts, and the three ways a ready check can end.

// File: rtl/crp_pkg.sv
package crp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_W_SELON,
        ST_W_PRE_HI,
        ST_W_PRE_LO,
        ST_W_SELOFF,
        ST_W_DATA,
        ST_W_ACK_HI,
        ST_W_ACK_LO,
        ST_R_SETUP,
        ST_R_HI,
        ST_R_LO,
        ST_R_POLL
    } crp_state_e;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_READY = 1'b1
    } crp_op_e;

    typedef struct packed {
        logic clk;
        logic sel;
        logic wr_en;
    } crp_ctl_t;

    localparam crp_ctl_t CTL_IDLE = '{clk: 1'b0, sel: 1'b0, wr_en: 1'b0};

    function automatic logic is_write_phase(input crp_state_e st);
        return st inside {ST_W_SELON, ST_W_PRE_HI, ST_W_PRE_LO, ST_W_SELOFF,
                          ST_W_DATA, ST_W_ACK_HI, ST_W_ACK_LO};
    endfunction

endpackage

// File: rtl/crp_hold_timer.sv
module crp_hold_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic [W-1:0] limit,
    output logic         last
);
    logic [W-1:0] cnt;

    assign last = (cnt == (limit - W'(1)));

    always_ff @(posedge clk) begin
        if (rst || restart || last)
            cnt <= '0;
        else
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/crp_step_counter.sv
module crp_step_counter #(
    parameter int COUNT = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int W = $clog2(COUNT + 1);
    localparam logic [W-1:0] LAST = W'(COUNT - 1);

    logic [W-1:0] cnt;

    assign hit = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + W'(1);
    end
endmodule

// File: rtl/crp_seq_core.sv
module crp_seq_core
    import crp_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int HALF_W      = 16,
    parameter int TW          = 16,
    parameter int POLL_CYCLES = 4000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] half_period,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              port_ack,
    input  logic              step_last,
    input  logic              pulse_hit,
    input  logic              try_hit,
    input  logic              poll_hit,
    output logic              timer_restart,
    output logic [TW-1:0]     timer_limit,
    output logic              cnt_clr,
    output logic              pulse_inc,
    output logic              try_inc,
    output logic              poll_inc,
    output crp_ctl_t          ctl,
    output logic [ADDR_W-1:0] port_addr,
    output logic [DATA_W-1:0] port_wdata,
    output logic              done,
    output logic              done_ok,
    output logic [ADDR_W-1:0] done_addr
);
    crp_state_e        state;
    logic [HALF_W-1:0] lim_q;
    logic [ADDR_W-1:0] tgt_addr;
    logic [DATA_W-1:0] tgt_data;

    assign cmd_ready     = (state == ST_IDLE);
    assign timer_restart = (state == ST_IDLE);
    assign timer_limit   = (state == ST_R_POLL) ? TW'(POLL_CYCLES) : TW'(lim_q);
    assign cnt_clr       = (state == ST_IDLE);
    assign pulse_inc     = (state == ST_W_PRE_LO) && step_last;
    assign try_inc       = (state == ST_W_ACK_HI) && step_last && !port_ack;
    assign poll_inc      = (state == ST_R_POLL) && step_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ctl        <= CTL_IDLE;
            port_addr  <= '0;
            port_wdata <= '0;
            lim_q      <= HALF_W'(1);
            tgt_addr   <= '0;
            tgt_data   <= '0;
            done       <= 1'b0;
            done_ok    <= 1'b0;
            done_addr  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        lim_q <= (half_period == '0) ? HALF_W'(1) : half_period;
                        if (crp_op_e'(cmd_kind) == OP_WRITE) begin
                            tgt_addr <= cmd_addr;
                            tgt_data <= cmd_data;
                            ctl.sel  <= 1'b1;
                            state    <= ST_W_SELON;
                        end else begin
                            tgt_addr   <= '0;
                            ctl        <= '{clk: 1'b0, sel: 1'b1, wr_en: 1'b0};
                            port_addr  <= '0;
                            port_wdata <= '0;
                            state      <= ST_R_SETUP;
                        end
                    end
                end
                ST_W_SELON: if (step_last) begin
                    ctl.clk <= 1'b1;
                    state   <= ST_W_PRE_HI;
                end
                ST_W_PRE_HI: if (step_last) begin
                    ctl.clk <= 1'b0;
                    state   <= ST_W_PRE_LO;
                end
                ST_W_PRE_LO: if (step_last) begin
                    if (pulse_hit) begin
                        ctl.sel <= 1'b0;
                        state   <= ST_W_SELOFF;
                    end else begin
                        ctl.clk <= 1'b1;
                        state   <= ST_W_PRE_HI;
                    end
                end
                ST_W_SELOFF: if (step_last) begin
                    port_wdata <= tgt_data;
                    ctl.wr_en  <= 1'b1;
                    state      <= ST_W_DATA;
                end
                ST_W_DATA: if (step_last) begin
                    port_addr <= tgt_addr;
                    ctl.sel   <= 1'b1;
                    ctl.clk   <= 1'b1;
                    state     <= ST_W_ACK_HI;
                end
                ST_W_ACK_HI: if (step_last) begin
                    if (port_ack || try_hit) begin
                        ctl.clk   <= 1'b0;
                        ctl.wr_en <= 1'b0;
                        done      <= 1'b1;
                        done_ok   <= port_ack;
                        done_addr <= tgt_addr;
                        state     <= ST_IDLE;
                    end else begin
                        ctl.clk <= 1'b0;
                        state   <= ST_W_ACK_LO;
                    end
                end
                ST_W_ACK_LO: if (step_last) begin
                    ctl.clk <= 1'b1;
                    state   <= ST_W_ACK_HI;
                end
                ST_R_SETUP: if (step_last) begin
                    ctl.clk <= 1'b1;
                    state   <= ST_R_HI;
                end
                ST_R_HI: if (step_last) begin
                    ctl.clk <= 1'b0;
                    state   <= ST_R_LO;
                end
                ST_R_LO: if (step_last) begin
                    state <= ST_R_POLL;
                end
                ST_R_POLL: if (step_last) begin
                    if (!port_ack || poll_hit) begin
                        ctl.clk   <= 1'b0;
                        ctl.wr_en <= 1'b0;
                        done      <= 1'b1;
                        done_ok   <= !port_ack;
                        done_addr <= tgt_addr;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/crp_write_master.sv
module crp_write_master #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int HALF_W      = 16,
    parameter int PRE_PULSES  = 15,
    parameter int ACK_TRIES   = 10,
    parameter int POLL_CYCLES = 4000,
    parameter int READY_POLLS = 500
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] half_period,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_kind,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              port_clk,
    output logic              port_sel,
    output logic              port_wr_en,
    output logic [ADDR_W-1:0] port_addr,
    output logic [DATA_W-1:0] port_wdata,
    input  logic              port_ack,
    output logic              done,
    output logic              done_ok,
    output logic [ADDR_W-1:0] done_addr
);
    import crp_pkg::*;

    localparam int POLL_W = $clog2(POLL_CYCLES + 1);
    localparam int TW     = (HALF_W > POLL_W) ? HALF_W : POLL_W;

    crp_ctl_t      ctl;
    logic          step_last, timer_restart;
    logic [TW-1:0] timer_limit;
    logic          cnt_clr, pulse_inc, try_inc, poll_inc;
    logic          pulse_hit, try_hit, poll_hit;

    assign port_clk   = ctl.clk;
    assign port_sel   = ctl.sel;
    assign port_wr_en = ctl.wr_en;

    crp_hold_timer #(.W(TW)) i_timer (
        .clk(clk), .rst(rst), .restart(timer_restart),
        .limit(timer_limit), .last(step_last)
    );

    crp_step_counter #(.COUNT(PRE_PULSES)) i_pulse_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(pulse_inc), .hit(pulse_hit)
    );

    crp_step_counter #(.COUNT(ACK_TRIES)) i_try_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(try_inc), .hit(try_hit)
    );

    crp_step_counter #(.COUNT(READY_POLLS)) i_poll_cnt (
        .clk(clk), .rst(rst), .clr(cnt_clr), .inc(poll_inc), .hit(poll_hit)
    );

    crp_seq_core #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALF_W(HALF_W),
        .TW(TW), .POLL_CYCLES(POLL_CYCLES)
    ) i_core (
        .clk(clk), .rst(rst), .half_period(half_period),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .port_ack(port_ack),
        .step_last(step_last), .pulse_hit(pulse_hit), .try_hit(try_hit),
        .poll_hit(poll_hit), .timer_restart(timer_restart),
        .timer_limit(timer_limit), .cnt_clr(cnt_clr), .pulse_inc(pulse_inc),
        .try_inc(try_inc), .poll_inc(poll_inc), .ctl(ctl),
        .port_addr(port_addr), .port_wdata(port_wdata),
        .done(done), .done_ok(done_ok), .done_addr(done_addr)
    );
endmodule

// File: rtl/crp_write_master_chk.sv
module crp_write_master_chk (
    input logic clk,
    input logic rst,
    input logic cmd_valid,
    input logic cmd_ready,
    input logic port_clk,
    input logic port_sel,
    input logic port_wr_en,
    input logic done
);
    assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    assert_clk_needs_sel_R5: assert property (@(posedge clk) disable iff (rst)
        port_clk |-> port_sel);

    assert_data_before_addr_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(port_wr_en) |-> (!port_sel && !port_clk));

    assert_clean_end_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!port_clk && !port_wr_en && cmd_ready));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

bind crp_write_master crp_write_master_chk i_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .port_clk(port_clk), .port_sel(port_sel), .port_wr_en(port_wr_en),
    .done(done)
);

// File: tb/test_crp_write_master.sv
module test_crp_write_master;
    localparam int PC = 6;
    localparam int NP = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] half_period = '0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_kind = 1'b0;
    logic [15:0] cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic        port_clk, port_sel, port_wr_en;
    logic [15:0] port_addr, port_wdata;
    logic        port_ack = 1'b0;
    logic        done, done_ok;
    logic [15:0] done_addr;

    crp_write_master #(.POLL_CYCLES(PC), .READY_POLLS(NP)) i_crp_write_master (
        .clk(clk), .rst(rst), .half_period(half_period), .cmd_valid(cmd_valid),
        .cmd_ready(cmd_ready), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .port_clk(port_clk), .port_sel(port_sel),
        .port_wr_en(port_wr_en), .port_addr(port_addr), .port_wdata(port_wdata),
        .port_ack(port_ack), .done(done), .done_ok(done_ok), .done_addr(done_addr)
    );

    always #5 clk = ~clk;

    typedef struct {
        bit        c, s, w;
        bit [15:0] a, d;
        bit        dn, ok;
        bit [15:0] da;
        bit        rdy, ack;
        string     tag;
    } exp_t;

    exp_t q[$];
    bit        m_clk, m_sel, m_we;
    bit [15:0] m_addr, m_wd;
    int checks = 0, failures = 0, cycles = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            failures = failures + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic void push(int n, string tag, bit ack_mid, bit ack_last);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.c = m_clk; e.s = m_sel; e.w = m_we; e.a = m_addr; e.d = m_wd;
            e.dn = 0; e.ok = 0; e.da = 0; e.rdy = 0;
            e.ack = (i == n - 1) ? ack_last : ack_mid;
            e.tag = tag;
            q.push_back(e);
        end
    endfunction

    function automatic void push_done(bit ok, bit [15:0] a, string tag);
        exp_t e;
        m_clk = 0; m_we = 0;
        e.c = 0; e.s = m_sel; e.w = 0; e.a = m_addr; e.d = m_wd;
        e.dn = 1; e.ok = ok; e.da = a; e.rdy = 1; e.ack = 0; e.tag = tag;
        q.push_back(e);
    endfunction

    // k: attempt that sees the acknowledge (1..10), 0 = never
    function automatic void build_write(bit [15:0] a, bit [15:0] d, int h, int k);
        m_sel = 1; push(h, "R3", 1, 1);
        for (int p = 0; p < 15; p++) begin
            m_clk = 1; push(h, "R3", 1, 1);
            m_clk = 0; push(h, "R3", 1, 1);
        end
        m_sel = 0; push(h, "R4", 1, 1);
        m_wd = d; m_we = 1; push(h, "R4", 1, 1);
        m_addr = a; m_sel = 1; m_clk = 1;
        for (int i = 1; i <= 10; i++) begin
            if (i == k) begin
                push(h, "R6", 0, 1);
                push_done(1, a, "R6");
                return;
            end
            push(h, "R6", 1, 0);
            if (i == 10) begin
                push_done(0, a, "R7");
                return;
            end
            m_clk = 0; push(h, "R6", 1, 1);
            m_clk = 1;
        end
    endfunction

    // m: number of polls that still see the acknowledge high
    function automatic void build_ready(int h, int m);
        m_clk = 0; m_addr = 0; m_sel = 1; m_wd = 0; m_we = 0;
        push(h, "R9", 1, 1);
        m_clk = 1; push(h, "R9", 1, 1);
        m_clk = 0; push(h, "R9", 1, 1);
        for (int j = 1; j <= NP; j++) begin
            push(PC, "R10", 1, (j <= m));
            if (j > m) begin
                push_done(1, 0, "R10");
                return;
            end
            if (j == NP) begin
                push_done(0, 0, "R10");
                return;
            end
        end
    endfunction

    task automatic compare(exp_t e);
        bit [37:0] act, exp;
        act = {port_clk, port_sel, port_wr_en, port_addr, port_wdata, done, cmd_ready};
        exp = {e.c, e.s, e.w, e.a, e.d, e.dn, e.rdy};
        checks++;
        if (act !== exp || (e.dn && ({done_ok, done_addr} !== {e.ok, e.da}))) begin
            failures++;
            $display("FAIL %s: actual ports=%h ok=%b daddr=%h expected ports=%h ok=%b daddr=%h",
                     e.tag, act, done_ok, done_addr, exp, e.ok, e.da);
        end
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e.c = m_clk; e.s = m_sel; e.w = m_we; e.a = m_addr; e.d = m_wd;
            e.dn = 0; e.ok = 0; e.da = 0; e.rdy = 1; e.ack = 0; e.tag = tag;
            compare(e);
            @(negedge clk);
        end
    endtask

    task automatic run_op(bit kind, bit [15:0] a, bit [15:0] d, bit [15:0] half,
                          int k, bit noise);
        int h;
        h = (half == 0) ? 1 : int'(half);
        checks++;
        if (cmd_ready !== 1'b1) begin
            failures++;
            $display("FAIL R1: cmd_ready actual=%b expected=1 before command", cmd_ready);
        end
        cmd_valid = 1; cmd_kind = kind; cmd_addr = a; cmd_data = d; half_period = half;
        if (kind) build_ready(h, k); else build_write(a, d, h, k);
        @(negedge clk);
        // R1 / R2: busy-time command noise and a changed half-period must not matter
        cmd_valid = noise; cmd_kind = ~kind; cmd_addr = a ^ 16'hFFFF;
        cmd_data = ~d; half_period = half + 16'd5;
        while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            compare(e);
            port_ack = e.ack;
            if (e.dn) cmd_valid = 0;
            @(negedge clk);
        end
        port_ack = 0;
        cmd_valid = 0;
    endtask

    initial begin
        m_clk = 0; m_sel = 0; m_we = 0; m_addr = 0; m_wd = 0;
        repeat (3) @(negedge clk);
        idle(1, "R12");
        rst = 0;
        idle(2, "R12");
        run_op(0, 16'h1234, 16'hBEEF, 16'd2, 1, 0);   // R6 first-try success
        idle(2, "R8");
        run_op(0, 16'h00A5, 16'h5A5A, 16'd0, 4, 1);   // R2 half=0, R1 noise
        idle(1, "R8");
        run_op(0, 16'hC0DE, 16'h0F0F, 16'd3, 0, 1);   // R7 failure after 10
        idle(2, "R8");
        run_op(0, 16'h8001, 16'h7FFE, 16'd1, 10, 0);  // R6 success on last attempt
        idle(1, "R8");
        run_op(1, 16'hFFFF, 16'hFFFF, 16'd2, 0, 0);   // R9/R10 immediate ready
        idle(1, "R11");
        run_op(1, 16'h0000, 16'h0000, 16'd1, 2, 1);   // R10 ready after two polls
        idle(1, "R11");
        run_op(1, 16'h1111, 16'h2222, 16'd2, NP, 0);  // R10 timeout
        idle(1, "R11");
        run_op(0, 16'h4242, 16'h1357, 16'd4, 2, 0);   // write after ready check
        idle(3, "R8");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule